// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block decides, every clock, whether a processor core should take an interrupt. It holds two small software-written registers. The first is a masked software request register, with one bit per software priority level. The second is the current priority level of the core. Alongside them it watches a vector of external hardware interrupt lines. From all pending requests it builds a summary bit vector and a single requested level.

When the requested level is nonzero and strictly above the current level, the block captures the summary and the level into its own output registers. It then raises a one-cycle trap request. No further trap is raised until the core acknowledges the previous one. A nonzero asynchronous-trap request is not supported: it raises an error flag and blocks trapping.

Software request bit `i` (for `i` in 4..18) stands for level `i - 3`. External line `k` sits at summary index `20 + k` and stands for level `20 + k`. Any pending external line therefore outranks every software level.

Top module: `ipl_resolver`

## Requirements
- R1: After reset, `sw_pending`, `cur_ipl`, `int_summary`, `int_id`, `trap_req` and `async_err` are all zero.
- R2: A write with `sw_wr_en` stores `sw_wr_data & 32'h0007_FFF0` into `sw_pending`, visible after the write edge. Bits 0..3 and 19..31 of the written value are dropped.
- R3: A write with `lvl_wr_en` stores `lvl_wr_data[4:0]` into `cur_ipl`, visible after the write edge. Upper bits are ignored.
- R4: A set bit `i` of `sw_pending` (4 <= i <= 18) requests level `i - 3`. When several bits are set, the highest index decides the level.
- R5: A high `ext_irq[k]` requests level `20 + k`. It replaces any software level. Among several lines, the highest `k` decides.
- R6: The summary holds bit `i` for each pending software bit `i`, and bit `20 + k` for each high external line `k`. All other bits are zero.
- R7: A trap is taken only when the requested level is nonzero and strictly greater than `cur_ipl`. An equal or lower level raises no trap.
- R8: `int_summary` and `int_id` load the summary and level at the same edge on which `trap_req` rises. They hold their values in every other cycle.
- R9: `trap_req` is high for exactly one cycle. No new trap is raised until `trap_ack` has been seen. After the acknowledge, a request that is still pending traps again.
- R10: While `async_req` is nonzero, `async_err` is high in the following cycle and no trap is raised in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 32 | Software request write value (masked) |
| lvl_wr_en | input | 1 | Write strobe for the current level register |
| lvl_wr_data | input | 32 | Current level write value (low 5 bits kept) |
| ext_irq | input | 8 | External interrupt lines, level sensitive |
| async_req | input | 4 | Asynchronous-trap request value; nonzero is unsupported |
| trap_ack | input | 1 | Core has accepted the last trap |
| sw_pending | output | 32 | Masked software request register |
| cur_ipl | output | 5 | Current priority level register |
| trap_req | output | 1 | One-cycle trap request |
| int_summary | output | 32 | Summary of requests captured at the last trap |
| int_id | output | 5 | Level captured at the last trap |
| async_err | output | 1 | Unsupported asynchronous-trap request seen |

## Verification
A wrong priority encode or offset shows as a wrong `int_id` on the first trap after the stimulus, one edge after the request becomes visible. A wrong mask shows in `sw_pending` right after the write edge. A busy flag that is stuck or cleared early shows within a few cycles: either a second trap pulse with no acknowledge, or no trap at all after an acknowledge while the request is still held. An off-by-one in the compare appears only when the requested level equals `cur_ipl`, so the tests place that boundary on both sides.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
   localparam int LVL_W = 5;
   typedef logic [LVL_W-1:0] ipl_t;
endpackage

// File: rtl/ipl_req_regs.sv
module ipl_req_regs
   import ipl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [DATA_W-1:0] sw_wr_data,
   input  logic              lvl_wr_en,
   input  logic [DATA_W-1:0] lvl_wr_data,
   output logic [DATA_W-1:0] sw_q,
   output ipl_t              lvl_q
);
   localparam logic [DATA_W-1:0] SW_MASK =
      ((DATA_W'(1) << SW_N) - DATA_W'(1)) << SW_LO;

   logic unused_lvl_hi;
   assign unused_lvl_hi = ^lvl_wr_data[DATA_W-1:LVL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (sw_wr_en)
            sw_q <= sw_wr_data & SW_MASK;
         if (lvl_wr_en)
            lvl_q <= lvl_wr_data[LVL_W-1:0];
      end
   end
endmodule

// File: rtl/ipl_scan.sv
module ipl_scan
   import ipl_pkg::*;
#(
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15,
   parameter int EXT_LO = 20,
   parameter int EXT_N  = 8,
   parameter int SUM_W  = 32
) (
   input  logic [SW_N-1:0]  sw_field,
   input  logic [EXT_N-1:0] ext_lines,
   output ipl_t             req_level,
   output logic [SUM_W-1:0] req_summary
);
   ipl_t sw_level;
   ipl_t ext_level;
   logic ext_any;

   // Low-to-high scan: the last hit, i.e. the highest index, wins.
   always_comb begin
      sw_level = '0;
      for (int i = 0; i < SW_N; i++)
         if (sw_field[i])
            sw_level = LVL_W'(i + 1);
   end

   always_comb begin
      ext_level = '0;
      for (int k = 0; k < EXT_N; k++)
         if (ext_lines[k])
            ext_level = LVL_W'(EXT_LO + k);
   end

   assign ext_any   = |ext_lines;
   assign req_level = ext_any ? ext_level : sw_level;

   generate
      for (genvar b = 0; b < SUM_W; b++) begin : g_sum
         if (b >= SW_LO && b < SW_LO + SW_N) begin : g_sw
            assign req_summary[b] = sw_field[b-SW_LO];
         end else if (b >= EXT_LO && b < EXT_LO + EXT_N) begin : g_ext
            assign req_summary[b] = ext_lines[b-EXT_LO];
         end else begin : g_zero
            assign req_summary[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/ipl_trap_ctl.sv
module ipl_trap_ctl
   import ipl_pkg::*;
#(
   parameter int SUM_W = 32,
   parameter int AST_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ipl_t             req_level,
   input  logic [SUM_W-1:0] req_summary,
   input  ipl_t             cur_level,
   input  logic [AST_W-1:0] async_req,
   input  logic             trap_ack,
   output logic             trap_req,
   output logic [SUM_W-1:0] int_summary,
   output ipl_t             int_id,
   output logic             async_err
);
   logic busy_q;
   logic async_hit;
   logic take;

   assign async_hit = |async_req;
   assign take = (req_level != '0) && (req_level > cur_level)
                 && !async_hit && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         trap_req    <= 1'b0;
         int_summary <= '0;
         int_id      <= '0;
         async_err   <= 1'b0;
      end else begin
         trap_req  <= take;
         async_err <= async_hit;
         if (take) begin
            busy_q      <= 1'b1;
            int_summary <= req_summary;
            int_id      <= req_level;
         end else if (trap_ack) begin
            busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ipl_resolver.sv
module ipl_resolver
   import ipl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15,
   parameter int EXT_LO = 20,
   parameter int EXT_N  = 8,
   parameter int AST_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic [DATA_W-1:0] sw_wr_data,
   input  logic              lvl_wr_en,
   input  logic [DATA_W-1:0] lvl_wr_data,
   input  logic [EXT_N-1:0]  ext_irq,
   input  logic [AST_W-1:0]  async_req,
   input  logic              trap_ack,
   output logic [DATA_W-1:0] sw_pending,
   output logic [LVL_W-1:0]  cur_ipl,
   output logic              trap_req,
   output logic [DATA_W-1:0] int_summary,
   output logic [LVL_W-1:0]  int_id,
   output logic              async_err
);
   localparam int SW_HI = SW_LO + SW_N - 1;
   localparam int EXT_HI = EXT_LO + EXT_N - 1;

   generate
      if (SW_HI >= EXT_LO) begin : g_bad_overlap
         $error("software field overlaps external range");
      end
      if (EXT_HI >= (1 << LVL_W) || EXT_HI >= DATA_W) begin : g_bad_range
         $error("external levels exceed level or summary width");
      end
      if (SW_N >= (1 << LVL_W) || SW_LO < 0) begin : g_bad_sw
         $error("software field does not fit the level width");
      end
   endgenerate

   ipl_t              lvl_q;
   ipl_t              req_level;
   logic [DATA_W-1:0] req_summary;
   ipl_t              id_q;

   ipl_req_regs #(.DATA_W(DATA_W), .SW_LO(SW_LO), .SW_N(SW_N)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_wr_en    (sw_wr_en),
      .sw_wr_data  (sw_wr_data),
      .lvl_wr_en   (lvl_wr_en),
      .lvl_wr_data (lvl_wr_data),
      .sw_q        (sw_pending),
      .lvl_q       (lvl_q)
   );

   ipl_scan #(.SW_LO(SW_LO), .SW_N(SW_N), .EXT_LO(EXT_LO), .EXT_N(EXT_N),
              .SUM_W(DATA_W)) u_scan (
      .sw_field    (sw_pending[SW_HI:SW_LO]),
      .ext_lines   (ext_irq),
      .req_level   (req_level),
      .req_summary (req_summary)
   );

   ipl_trap_ctl #(.SUM_W(DATA_W), .AST_W(AST_W)) u_trap (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_level   (req_level),
      .req_summary (req_summary),
      .cur_level   (lvl_q),
      .async_req   (async_req),
      .trap_ack    (trap_ack),
      .trap_req    (trap_req),
      .int_summary (int_summary),
      .int_id      (id_q),
      .async_err   (async_err)
   );

   assign cur_ipl = lvl_q;
   assign int_id  = id_q;
endmodule

// File: rtl/ipl_resolver_chk.sv
module ipl_resolver_chk #(
   parameter int DATA_W = 32,
   parameter int SW_LO  = 4,
   parameter int SW_N   = 15,
   parameter int AST_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_wr_en,
   input logic [DATA_W-1:0] sw_wr_data,
   input logic              lvl_wr_en,
   input logic [DATA_W-1:0] lvl_wr_data,
   input logic [AST_W-1:0]  async_req,
   input logic [DATA_W-1:0] sw_pending,
   input logic [4:0]        cur_ipl,
   input logic              trap_req,
   input logic [DATA_W-1:0] int_summary,
   input logic [4:0]        int_id,
   input logic              async_err
);
   localparam logic [DATA_W-1:0] CHK_MASK =
      ((DATA_W'(1) << SW_N) - DATA_W'(1)) << SW_LO;

   assert_sw_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en |=> sw_pending == ($past(sw_wr_data) & CHK_MASK));

   assert_lvl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_wr_en |=> cur_ipl == $past(lvl_wr_data[4:0]));

   assert_strict_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (int_id != 5'd0) && (int_id > $past(cur_ipl)));

   assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> $stable(int_id) && $stable(int_summary));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !trap_req);

   assert_async_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|async_req) |=> async_err && !trap_req);
endmodule

bind ipl_resolver ipl_resolver_chk #(
   .DATA_W(DATA_W), .SW_LO(SW_LO), .SW_N(SW_N), .AST_W(AST_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_wr_en    (sw_wr_en),
   .sw_wr_data  (sw_wr_data),
   .lvl_wr_en   (lvl_wr_en),
   .lvl_wr_data (lvl_wr_data),
   .async_req   (async_req),
   .sw_pending  (sw_pending),
   .cur_ipl     (cur_ipl),
   .trap_req    (trap_req),
   .int_summary (int_summary),
   .int_id      (int_id),
   .async_err   (async_err)
);

// File: tb/ipl_resolver_bench.sv
`timescale 1ns/1ps
module ipl_resolver_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wr_data = '0;
   logic        lvl_wr_en = 1'b0;
   logic [31:0] lvl_wr_data = '0;
   logic [7:0]  ext_irq = '0;
   logic [3:0]  async_req = '0;
   logic        trap_ack = 1'b0;
   logic [31:0] sw_pending;
   logic [4:0]  cur_ipl;
   logic        trap_req;
   logic [31:0] int_summary;
   logic [4:0]  int_id;
   logic        async_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ipl_resolver u_ipl_resolver (
      .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data), .ext_irq(ext_irq),
      .async_req(async_req), .trap_ack(trap_ack), .sw_pending(sw_pending),
      .cur_ipl(cur_ipl), .trap_req(trap_req), .int_summary(int_summary),
      .int_id(int_id), .async_err(async_err)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_sw(input logic [31:0] d);
      sw_wr_en = 1'b1; sw_wr_data = d;
      step();
      sw_wr_en = 1'b0;
   endtask

   task automatic wr_ipl(input logic [31:0] d);
      lvl_wr_en = 1'b1; lvl_wr_data = d;
      step();
      lvl_wr_en = 1'b0;
   endtask

   task automatic expect_trap(input logic [4:0] id, input logic [31:0] sum, input string tag);
      step();
      chk({31'd0, trap_req}, 32'd1, {tag, " trap_req"});
      chk({27'd0, int_id}, {27'd0, id}, {tag, " int_id"});
      chk(int_summary, sum, {tag, " int_summary"});
      step();
      chk({31'd0, trap_req}, 32'd0, "R9 pulse ends");
   endtask

   task automatic expect_quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         step();
         chk({31'd0, trap_req}, 32'd0, tag);
      end
   endtask

   task automatic clear_ack();
      ext_irq = '0;
      wr_sw(32'd0);
      trap_ack = 1'b1;
      step();
      trap_ack = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk(sw_pending, 0, "R1 sw_pending");
      chk({27'd0, cur_ipl}, 0, "R1 cur_ipl");
      chk(int_summary, 0, "R1 int_summary");
      chk({27'd0, int_id}, 0, "R1 int_id");
      chk({30'd0, trap_req, async_err}, 0, "R1 trap/err");
   endtask

   task automatic t_masks();
      wr_ipl(32'hFFFF_FFE7);
      chk({27'd0, cur_ipl}, 32'h7, "R3 low five bits");
      wr_ipl(32'd31);
      wr_sw(32'hFFFF_FFFF);
      chk(sw_pending, 32'h0007_FFF0, "R2 mask");
      expect_quiet(3, "R7 level 15 under 31");
      wr_sw(32'd0);
      wr_ipl(32'd0);
   endtask

   task automatic t_sw_levels();
      wr_sw(32'h10);
      expect_trap(5'd1, 32'h10, "R4 bit4 level1");
      clear_ack();
      wr_sw(32'h820);
      expect_trap(5'd8, 32'h820, "R4 highest bit11 R6");
      clear_ack();
      wr_sw(32'h000C_000F);
      chk(sw_pending, 32'h0004_0000, "R2 outer bits dropped");
      expect_trap(5'd15, 32'h0004_0000, "R4 bit18 level15");
      clear_ack();
   endtask

   task automatic t_compare();
      wr_ipl(32'd8);
      wr_sw(32'h800);
      expect_quiet(3, "R7 equal level no trap");
      wr_ipl(32'd7);
      expect_trap(5'd8, 32'h800, "R7 above by one");
      clear_ack();
      wr_ipl(32'd0);
   endtask

   task automatic t_external();
      wr_ipl(32'd31);
      wr_sw(32'h10);
      ext_irq = 8'h05;
      wr_ipl(32'd0);
      expect_trap(5'd22, 32'h0050_0010, "R5 override R6 summary");
      clear_ack();
      ext_irq = 8'h80;
      expect_trap(5'd27, 32'h0800_0000, "R5 line7 level27");
      clear_ack();
   endtask

   task automatic t_handshake();
      ext_irq = 8'h02;
      expect_trap(5'd21, 32'h0020_0000, "R9 first");
      expect_quiet(4, "R9 no retrap before ack");
      ext_irq = 8'h04;
      step(); step();
      chk({27'd0, int_id}, 32'd21, "R8 id held while busy");
      chk(int_summary, 32'h0020_0000, "R8 summary held");
      trap_ack = 1'b1;
      step();
      trap_ack = 1'b0;
      chk({31'd0, trap_req}, 0, "R9 none at ack edge");
      expect_trap(5'd22, 32'h0040_0000, "R9 retrap after ack");
      clear_ack();
   endtask

   task automatic t_async();
      async_req = 4'h2;
      ext_irq = 8'h01;
      step();
      chk({31'd0, async_err}, 1, "R10 err raised");
      chk({31'd0, trap_req}, 0, "R10 no trap");
      expect_quiet(2, "R10 still blocked");
      async_req = 4'h0;
      expect_trap(5'd20, 32'h0010_0000, "R10 trap after clear");
      chk({31'd0, async_err}, 0, "R10 err cleared");
      clear_ack();
   endtask

   initial begin
      t_reset();
      t_masks();
      t_sw_levels();
      t_compare();
      t_external();
      t_handshake();
      t_async();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule